// File: doc/BRIEF.md
# Ping-Pong Cell Transmit Buffer

This block sends fixed-length cells out of a 4-bit port that runs on its own transmit clock, unrelated to the system clock. A controller on the system-clock side writes one byte per cycle into one of two cell buffers. When the final byte of a cell has been written, that buffer is handed to the transmit side. The other buffer then becomes the target of the next write. The transmit side streams each handed-over cell out as nibbles and raises a start-of-cell strobe for the first nibble.

The length of each cell is chosen by a small select code that is sampled when the first byte of the cell is written. This lets the output cell length be set with no link to any receive-side setting. Every cell carries its own length through the buffer. A single status output, `load_free`, tells the controller whether the buffer it would write next can take a cell. A buffer becomes free again only after its last nibble has left the port.

The handover between the clock domains uses one toggle flag per buffer and direction, each passed through a multi-stage synchronizer. Cells leave in the order they were completed. A cell that is waiting follows the previous cell with no idle gap.

Top module: `cell_tx_pingpong`

## Requirements
- R1: While either reset is asserted, and on the first cycle after release, `tx_nib` is 0, `tx_soc` is 0 and `load_free` is 1.
- R2: The select code sampled with the first byte of a cell sets its length in bytes: codes 0 to 4 give 52 + code, and codes 5 to 7 give 56. A change of the code in the middle of a cell has no effect on that cell.
- R3: `tx_soc` is 1 during the first nibble cycle of each cell and 0 in every other cycle.
- R4: Bytes leave in the order they were written, starting at byte 0. Each byte is sent as bits [7:4] in one transmit cycle followed by bits [3:0] in the next, so a cell of L bytes takes exactly 2L consecutive cycles.
- R5: In any transmit cycle that carries no cell nibble, `tx_nib` is 0 and `tx_soc` is 0.
- R6: Each completed cell is sent exactly once, in completion order. If the port is idle, the first nibble of a cell appears within 8 transmit cycles of the write of its last byte.
- R7: If a cell is completed at least 8 transmit cycles before the last nibble of the cell being sent, its first nibble appears in the very next transmit cycle, with no idle cycle between the two cells.
- R8: `load_free` is 0 while both buffers hold cells that have not been fully sent. It stays 0 until the last nibble of the older cell has been driven, and returns to 1 within 8 system cycles after that.
- R9: A byte presented with `wr_valid` while `load_free` is 0 is dropped. It changes no stored cell, and the next accepted byte is byte 0 of a new cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock for the load side |
| sys_rst_n | input | 1 | Active-low asynchronous reset, system domain |
| cfg_len_sel | input | 3 | Cell length select code, sampled with byte 0 |
| wr_valid | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte to store |
| load_free | output | 1 | The buffer to be written next can take a cell |
| tx_clk | input | 1 | Transmit port clock |
| tx_rst_n | input | 1 | Active-low asynchronous reset, transmit domain |
| tx_nib | output | 4 | Transmit nibble |
| tx_soc | output | 1 | Start-of-cell strobe on the first nibble |

## Verification
The assertions assume that `wr_valid`, `wr_data` and `cfg_len_sel` change only in step with `sys_clk`, and that the two resets are released while both clocks are running. The bench therefore drives every input on the falling edge of the system clock. The nibble-count properties take for granted that the stored length of the buffer being sent does not change while that buffer is on the port. The stimulus respects this by writing only when `load_free` is high. The one exception is the deliberate burst of dropped bytes, which must leave that length untouched. The transmit clock period is 7 ns against a 4 ns system clock, so handovers land at varying phases.

// File: rtl/cell_tx_pkg.sv
`timescale 1ns/1ps
package cell_tx_pkg;
   // Position of the serializer within the cell on the port.
   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_SECOND = 2'd1,
      PH_FIRST  = 2'd2
   } tx_phase_e;

   // The scheme is a strict ping-pong.
   localparam int NUM_BANKS = 2;
endpackage

// File: rtl/cell_tx_sync.sv
`timescale 1ns/1ps
module cell_tx_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("cell_tx_sync: STAGES must be at least 2");
   end

   if (STAGES == 2) begin : g_two
      logic [WIDTH-1:0] meta_q, sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
         end else begin
            meta_q <= d;
            sync_q <= meta_q;
         end
      end
      assign q = sync_q;
   end else begin : g_chain
      logic [STAGES-1:0][WIDTH-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= '0;
         else        chain_q <= {chain_q[STAGES-2:0], d};
      end
      assign q = chain_q[STAGES-1];
   end
endmodule

// File: rtl/cell_tx_store.sv
`timescale 1ns/1ps
module cell_tx_store #(
   parameter int BYTE_W = 8,
   parameter int DEPTH  = 56,
   parameter int IDX_W  = 6
) (
   input  logic              wclk,
   input  logic              we,
   input  logic              wbank,
   input  logic [IDX_W-1:0]  waddr,
   input  logic [BYTE_W-1:0] wdata,
   input  logic              rbank,
   input  logic [IDX_W-1:0]  raddr,
   output logic [BYTE_W-1:0] rdata
);
   import cell_tx_pkg::*;

   logic [NUM_BANKS-1:0][BYTE_W-1:0] bank_rd;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic [BYTE_W-1:0] cells [DEPTH];
      always_ff @(posedge wclk) begin
         if (we && (wbank == 1'(b))) cells[waddr] <= wdata;
      end
      assign bank_rd[b] = cells[raddr];
   end

   assign rdata = bank_rd[rbank];
endmodule

// File: rtl/cell_tx_loader.sv
`timescale 1ns/1ps
module cell_tx_loader #(
   parameter int BYTE_W  = 8,
   parameter int MIN_LEN = 52,
   parameter int MAX_LEN = 56,
   parameter int SEL_W   = 3,
   parameter int LEN_W   = 6,
   parameter int IDX_W   = 6
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [SEL_W-1:0]            cfg_len_sel,
   input  logic                        wr_valid,
   input  logic [BYTE_W-1:0]           wr_data,
   input  logic [1:0]                  drain_sync,
   output logic                        load_free,
   output logic                        mem_we,
   output logic                        mem_bank,
   output logic [IDX_W-1:0]            mem_addr,
   output logic [BYTE_W-1:0]           mem_data,
   output logic [1:0]                  full_tgl,
   output logic [1:0][LEN_W-1:0]       bank_len,
   output logic [IDX_W-1:0]            fill_idx
);
   localparam int SPAN = MAX_LEN - MIN_LEN;

   logic             wr_sel;
   logic [LEN_W-1:0] cur_len;
   logic [LEN_W-1:0] sel_len;
   logic [LEN_W-1:0] cell_len;
   logic             accept;
   logic             at_last;

   // Select code to byte count, saturating at the longest cell.
   always_comb begin
      if (cfg_len_sel > SEL_W'(SPAN)) sel_len = LEN_W'(MAX_LEN);
      else                            sel_len = LEN_W'(MIN_LEN) + LEN_W'(cfg_len_sel);
   end

   assign cell_len  = (fill_idx == '0) ? sel_len : cur_len;
   assign load_free = (full_tgl[wr_sel] == drain_sync[wr_sel]);
   assign accept    = wr_valid && load_free;
   assign at_last   = (LEN_W'(fill_idx) == (cell_len - LEN_W'(1)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_sel   <= 1'b0;
         fill_idx <= '0;
         cur_len  <= '0;
         full_tgl <= '0;
         bank_len <= '0;
      end else if (accept) begin
         if (fill_idx == '0) begin
            cur_len          <= cell_len;
            bank_len[wr_sel] <= cell_len;
         end
         if (at_last) begin
            fill_idx         <= '0;
            full_tgl[wr_sel] <= ~full_tgl[wr_sel];
            wr_sel           <= ~wr_sel;
         end else begin
            fill_idx <= fill_idx + 1'b1;
         end
      end
   end

   assign mem_we   = accept;
   assign mem_bank = wr_sel;
   assign mem_addr = fill_idx;
   assign mem_data = wr_data;
endmodule

// File: rtl/cell_tx_serial.sv
`timescale 1ns/1ps
module cell_tx_serial #(
   parameter int BYTE_W   = 8,
   parameter int NIB_W    = 4,
   parameter int LEN_W    = 6,
   parameter int IDX_W    = 6,
   parameter bit HI_FIRST = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [1:0]            full_sync,
   input  logic [1:0][LEN_W-1:0] bank_len,
   output logic                  rd_bank,
   output logic [IDX_W-1:0]      rd_addr,
   input  logic [BYTE_W-1:0]     rd_data,
   output logic [1:0]            drain_tgl,
   output logic [LEN_W-1:0]      out_len,
   output logic [NIB_W-1:0]      tx_nib,
   output logic                  tx_soc
);
   import cell_tx_pkg::*;

   tx_phase_e        phase;
   logic             rd_sel;
   logic [IDX_W-1:0] byte_idx;
   logic [NIB_W-1:0] nib_a, nib_b;
   logic             pending;
   logic             last_byte;

   if (HI_FIRST) begin : g_hi_first
      assign nib_a = rd_data[BYTE_W-1:NIB_W];
      assign nib_b = rd_data[NIB_W-1:0];
   end else begin : g_lo_first
      assign nib_a = rd_data[NIB_W-1:0];
      assign nib_b = rd_data[BYTE_W-1:NIB_W];
   end

   assign pending   = (full_sync[rd_sel] != drain_tgl[rd_sel]);
   assign out_len   = bank_len[rd_sel];
   assign last_byte = (LEN_W'(byte_idx) == (out_len - LEN_W'(1)));
   assign rd_bank   = rd_sel;
   assign rd_addr   = (phase == PH_IDLE) ? '0 : byte_idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_IDLE;
         rd_sel    <= 1'b0;
         byte_idx  <= '0;
         drain_tgl <= '0;
         tx_nib    <= '0;
         tx_soc    <= 1'b0;
      end else begin
         case (phase)
            PH_IDLE: begin
               if (pending) begin
                  tx_nib   <= nib_a;
                  tx_soc   <= 1'b1;
                  byte_idx <= '0;
                  phase    <= PH_SECOND;
               end else begin
                  tx_nib <= '0;
                  tx_soc <= 1'b0;
               end
            end
            PH_SECOND: begin
               tx_nib <= nib_b;
               tx_soc <= 1'b0;
               if (last_byte) begin
                  drain_tgl[rd_sel] <= ~drain_tgl[rd_sel];
                  rd_sel            <= ~rd_sel;
                  phase             <= PH_IDLE;
               end else begin
                  byte_idx <= byte_idx + 1'b1;
                  phase    <= PH_FIRST;
               end
            end
            PH_FIRST: begin
               tx_nib <= nib_a;
               tx_soc <= 1'b0;
               phase  <= PH_SECOND;
            end
            default: begin
               tx_nib <= '0;
               tx_soc <= 1'b0;
               phase  <= PH_IDLE;
            end
         endcase
      end
   end
endmodule

// File: rtl/cell_tx_pingpong.sv
`timescale 1ns/1ps
module cell_tx_pingpong #(
   parameter int BYTE_W      = 8,
   parameter int NIB_W       = 4,
   parameter int MIN_LEN     = 52,
   parameter int MAX_LEN     = 56,
   parameter int SEL_W       = 3,
   parameter int SYNC_STAGES = 2,
   parameter bit HI_FIRST    = 1'b1
) (
   input  logic              sys_clk,
   input  logic              sys_rst_n,
   input  logic [SEL_W-1:0]  cfg_len_sel,
   input  logic              wr_valid,
   input  logic [BYTE_W-1:0] wr_data,
   output logic              load_free,
   input  logic              tx_clk,
   input  logic              tx_rst_n,
   output logic [NIB_W-1:0]  tx_nib,
   output logic              tx_soc
);
   localparam int LEN_W = $clog2(MAX_LEN + 1);
   localparam int IDX_W = $clog2(MAX_LEN);

   if (BYTE_W != 2 * NIB_W) begin : g_bad_width
      $error("cell_tx_pingpong: BYTE_W must be twice NIB_W");
   end
   if (MIN_LEN < 2 || MIN_LEN > MAX_LEN) begin : g_bad_len
      $error("cell_tx_pingpong: need 2 <= MIN_LEN <= MAX_LEN");
   end
   if ((MAX_LEN - MIN_LEN) >= (1 << SEL_W)) begin : g_bad_sel
      $error("cell_tx_pingpong: SEL_W too narrow for the length span");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("cell_tx_pingpong: SYNC_STAGES must be at least 2");
   end

   logic                  mem_we, mem_bank, rd_bank;
   logic [IDX_W-1:0]      mem_addr, rd_addr, fill_idx;
   logic [BYTE_W-1:0]     mem_data, rd_data;
   logic [1:0]            full_tgl, full_sync, drain_tgl, drain_sync;
   logic [1:0][LEN_W-1:0] bank_len;
   logic [LEN_W-1:0]      out_len;

   cell_tx_loader #(
      .BYTE_W(BYTE_W), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN),
      .SEL_W(SEL_W), .LEN_W(LEN_W), .IDX_W(IDX_W)
   ) u_load (
      .clk(sys_clk), .rst_n(sys_rst_n), .cfg_len_sel(cfg_len_sel),
      .wr_valid(wr_valid), .wr_data(wr_data), .drain_sync(drain_sync),
      .load_free(load_free), .mem_we(mem_we), .mem_bank(mem_bank),
      .mem_addr(mem_addr), .mem_data(mem_data), .full_tgl(full_tgl),
      .bank_len(bank_len), .fill_idx(fill_idx)
   );

   cell_tx_store #(
      .BYTE_W(BYTE_W), .DEPTH(MAX_LEN), .IDX_W(IDX_W)
   ) u_store (
      .wclk(sys_clk), .we(mem_we), .wbank(mem_bank), .waddr(mem_addr),
      .wdata(mem_data), .rbank(rd_bank), .raddr(rd_addr), .rdata(rd_data)
   );

   cell_tx_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_full_sync (
      .clk(tx_clk), .rst_n(tx_rst_n), .d(full_tgl), .q(full_sync)
   );

   cell_tx_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_drain_sync (
      .clk(sys_clk), .rst_n(sys_rst_n), .d(drain_tgl), .q(drain_sync)
   );

   cell_tx_serial #(
      .BYTE_W(BYTE_W), .NIB_W(NIB_W), .LEN_W(LEN_W), .IDX_W(IDX_W),
      .HI_FIRST(HI_FIRST)
   ) u_ser (
      .clk(tx_clk), .rst_n(tx_rst_n), .full_sync(full_sync),
      .bank_len(bank_len), .rd_bank(rd_bank), .rd_addr(rd_addr),
      .rd_data(rd_data), .drain_tgl(drain_tgl), .out_len(out_len),
      .tx_nib(tx_nib), .tx_soc(tx_soc)
   );
endmodule

// File: rtl/cell_tx_pingpong_chk.sv
`timescale 1ns/1ps
module cell_tx_pingpong_chk #(
   parameter int MIN_LEN = 52,
   parameter int MAX_LEN = 56,
   parameter int LEN_W   = 6,
   parameter int IDX_W   = 6,
   parameter int NIB_W   = 4
) (
   input logic             sys_clk,
   input logic             sys_rst_n,
   input logic             wr_valid,
   input logic             load_free,
   input logic [IDX_W-1:0] fill_idx,
   input logic             tx_clk,
   input logic             tx_rst_n,
   input logic             tx_soc,
   input logic [NIB_W-1:0] tx_nib,
   input logic [LEN_W-1:0] out_len
);
   localparam int CNT_W = $clog2(2 * MAX_LEN + 1);

   // Nibbles of the current cell already seen on the port, and the cell size.
   logic [CNT_W-1:0] seen_q, cap_q;

   always_ff @(posedge tx_clk or negedge tx_rst_n) begin
      if (!tx_rst_n) begin
         seen_q <= '0;
         cap_q  <= '0;
      end else if (tx_soc) begin
         seen_q <= CNT_W'(1);
         cap_q  <= CNT_W'({out_len, 1'b0});
      end else if (seen_q != '0 && seen_q < cap_q) begin
         seen_q <= seen_q + 1'b1;
      end else begin
         seen_q <= '0;
      end
   end

   assert_soc_single_R3: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
      tx_soc |=> !tx_soc);

   assert_soc_boundary_R3: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
      tx_soc |-> (seen_q == '0 || seen_q == cap_q));

   assert_idle_zero_R5: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
      (!tx_soc && (seen_q == '0 || seen_q >= cap_q)) |-> (tx_nib == '0));

   assert_len_range_R2: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
      tx_soc |-> (out_len >= LEN_W'(MIN_LEN) && out_len <= LEN_W'(MAX_LEN)));

   assert_drop_when_busy_R9: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
      (wr_valid && !load_free) |=> $stable(fill_idx));

   assert_fill_bound_R2: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
      fill_idx < IDX_W'(MAX_LEN));
endmodule

bind cell_tx_pingpong cell_tx_pingpong_chk #(
   .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN), .LEN_W(LEN_W), .IDX_W(IDX_W), .NIB_W(NIB_W)
) u_chk (
   .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .wr_valid(wr_valid),
   .load_free(load_free), .fill_idx(fill_idx), .tx_clk(tx_clk),
   .tx_rst_n(tx_rst_n), .tx_soc(tx_soc), .tx_nib(tx_nib), .out_len(out_len)
);

// File: tb/cell_tx_pingpong_test.sv
`timescale 1ns/1ps
module cell_tx_pingpong_test;
   logic       sys_clk = 1'b0;
   logic       tx_clk  = 1'b0;
   logic       sys_rst_n, tx_rst_n;
   logic [2:0] cfg_len_sel;
   logic       wr_valid;
   logic [7:0] wr_data;
   logic       load_free;
   logic [3:0] tx_nib;
   logic       tx_soc;

   always #2   sys_clk = ~sys_clk;
   always #3.5 tx_clk  = ~tx_clk;

   cell_tx_pingpong uut (
      .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .cfg_len_sel(cfg_len_sel),
      .wr_valid(wr_valid), .wr_data(wr_data), .load_free(load_free),
      .tx_clk(tx_clk), .tx_rst_n(tx_rst_n), .tx_nib(tx_nib), .tx_soc(tx_soc)
   );

   int n_cmp = 0, n_bad = 0;
   bit finished = 0;

   // Reference model state: expected cells in completion order.
   logic [7:0] exp_bytes[$];
   int         exp_len[$];
   int         exp_commit[$];
   bit         model_on = 0;
   bit         in_cell = 0, just_ended = 0;
   int         txcyc = 0, done_cnt = 0, idle_wait = 0;
   int         nib_idx = 0, cur_len = 0, end_cyc = 0;

   task automatic chk(bit ok, string req, string what, int act, int expv);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   function automatic logic [7:0] pat(int seed, int i);
      return 8'((seed * 37 + i * 11 + 5) ^ (i << 3));
   endfunction

   // Transmit-side comparison on every port cycle.
   always @(negedge tx_clk) begin
      bit         prev_end;
      logic [7:0] b;
      int         e;
      if (model_on) begin
         txcyc++;
         prev_end   = just_ended;
         just_ended = 0;
         if (in_cell) begin
            b = exp_bytes[nib_idx / 2];
            e = (nib_idx % 2 == 0) ? int'(b[7:4]) : int'(b[3:0]);
            chk(tx_soc == 1'b0, "R3", "strobe inside cell", int'(tx_soc), 0);
            chk(tx_nib == 4'(e), "R2/R4", "cell nibble", int'(tx_nib), e);
            nib_idx++;
            if (nib_idx == 2 * cur_len) begin
               repeat (cur_len) void'(exp_bytes.pop_front());
               void'(exp_len.pop_front());
               void'(exp_commit.pop_front());
               in_cell    = 0;
               done_cnt++;
               just_ended = 1;
               end_cyc    = txcyc;
            end
         end else if (tx_soc) begin
            if (exp_len.size() == 0) begin
               chk(0, "R6", "cell start with none completed", 1, 0);
            end else begin
               cur_len = exp_len[0];
               b = exp_bytes[0];
               chk(tx_nib == b[7:4], "R4", "first nibble", int'(tx_nib), int'(b[7:4]));
               nib_idx   = 1;
               in_cell   = 1;
               idle_wait = 0;
            end
         end else begin
            chk(tx_nib == 4'd0, "R5", "idle nibble", int'(tx_nib), 0);
            if (prev_end && exp_len.size() > 0 && exp_commit[0] <= end_cyc - 8)
               chk(0, "R7", "idle gap between cells", 0, 1);
            if (exp_len.size() > 0) begin
               idle_wait++;
               if (idle_wait > 8) begin
                  chk(0, "R6", "cell start latency", idle_wait, 8);
                  idle_wait = 0;
               end
            end
         end
      end
   end

   task automatic wait_free();
      while (load_free !== 1'b1) @(negedge sys_clk);
   endtask

   // Write one cell; sel_mid (if >= 0) is driven after byte 0 (R2 sampling).
   task automatic put_cell(int sel, int seed, int sel_mid = -1);
      int len;
      len = (sel > 4) ? 56 : 52 + sel;
      wait_free();
      for (int i = 0; i < len; i++) begin
         cfg_len_sel = 3'((i == 0 || sel_mid < 0) ? sel : sel_mid);
         wr_valid    = 1'b1;
         wr_data     = pat(seed, i);
         @(negedge sys_clk);
      end
      wr_valid = 1'b0;
      for (int i = 0; i < len; i++) exp_bytes.push_back(pat(seed, i));
      exp_len.push_back(len);
      exp_commit.push_back(txcyc);
   endtask

   // Both buffers occupied: low until the older cell ends, then high soon (R8).
   task automatic check_full_then_free(int target);
      int c;
      while (done_cnt < target) begin
         chk(load_free == 1'b0, "R8", "free before last nibble", int'(load_free), 0);
         @(negedge sys_clk);
      end
      c = 0;
      while (load_free !== 1'b1 && c <= 8) begin
         @(negedge sys_clk);
         c++;
      end
      chk(load_free == 1'b1, "R8", "free after drain", c, 8);
   endtask

   task automatic wait_done(int target);
      while (done_cnt < target) @(negedge sys_clk);
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      sys_rst_n   = 1'b0;
      tx_rst_n    = 1'b0;
      cfg_len_sel = 3'd0;
      wr_valid    = 1'b0;
      wr_data     = 8'd0;
      repeat (5) @(negedge sys_clk);
      chk(tx_nib == 4'd0, "R1", "nibble in reset", int'(tx_nib), 0);
      chk(tx_soc == 1'b0, "R1", "strobe in reset", int'(tx_soc), 0);
      chk(load_free == 1'b1, "R1", "free in reset", int'(load_free), 1);
      sys_rst_n = 1'b1;
      tx_rst_n  = 1'b1;
      @(negedge sys_clk);
      chk(tx_nib == 4'd0, "R1", "nibble after release", int'(tx_nib), 0);
      chk(tx_soc == 1'b0, "R1", "strobe after release", int'(tx_soc), 0);
      chk(load_free == 1'b1, "R1", "free after release", int'(load_free), 1);
      model_on = 1;
      repeat (20) @(negedge sys_clk);

      // Single shortest cell on an idle port.
      put_cell(0, 1);
      wait_done(1);
      repeat (10) @(negedge sys_clk);

      // Two cells back to back, then dropped writes while both are held.
      put_cell(4, 2);
      put_cell(1, 3);
      chk(load_free == 1'b0, "R8", "both buffers held", int'(load_free), 0);
      for (int i = 0; i < 10; i++) begin
         wr_valid = 1'b1;
         wr_data  = 8'hA5;
         @(negedge sys_clk);
         chk(load_free == 1'b0, "R9", "still full during dropped writes", int'(load_free), 0);
      end
      wr_valid = 1'b0;
      check_full_then_free(2);

      // Code 6 saturates to 56; a mid-cell change to code 0 must not matter.
      put_cell(6, 4, 0);
      put_cell(7, 5);
      put_cell(3, 6);
      put_cell(2, 7);
      put_cell(5, 8);
      wait_done(8);
      repeat (40) @(negedge sys_clk);
      chk(exp_len.size() == 0, "R6", "cells still expected", exp_len.size(), 0);
      chk(load_free == 1'b1, "R8", "free when drained", int'(load_free), 1);
      summary();
   end

   initial begin
      repeat (200000) @(posedge sys_clk);
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", done_cnt, 8);
      summary();
   end
endmodule